// File: doc/BRIEF.md
# Thread Block Dispatcher

The dispatcher hands the thread blocks of one launched grid to a row of multiprocessor slots. Each block goes whole to a single slot. A launch command gives four values: the number of blocks, the threads in each block, the registers each thread needs, and the shared-memory bytes each block needs. For every slot the dispatcher keeps four counts: resident blocks, resident threads, resident registers and resident shared memory. A block is offered to a slot only when all four counts stay within that slot's limits after the block is added.

Blocks leave in ascending ID order through a valid/ready handshake that carries the block ID and the target slot. When a slot finishes a block, a completion pulse names that slot. The block's resources are then returned, so blocks that are still waiting can fill the freed space. Once every block has been dispatched and every one has reported completion, a grid-done level rises and stays up until the next accepted launch. A launch in which one block on its own would overflow an empty slot is refused: an error flag rises and nothing is dispatched.

Top module: `blk_dispatch`

## Requirements
- R1: After reset, `disp_valid`, `grid_done` and `launch_err` are all 0.
- R2: Block IDs are offered in order 0, 1, ..., N-1, each exactly once. `disp_valid` is high exactly when a grid is running, some block is not yet dispatched, and at least one slot can take a block.
- R3: The offered slot `disp_mp` is the lowest-numbered slot where the block fits.
- R4: No slot ever holds more than MAX_BLK resident blocks (default 8).
- R5: The resident threads of a slot never exceed MAX_THR (default 768). For example, blocks of 256 threads fit three to a slot.
- R6: The resident registers of a slot never exceed MAX_REG (default 8192). A block's register footprint is `launch_threads` × `launch_rpt`.
- R7: The resident shared memory of a slot never exceeds MAX_SMEM bytes (default 16384). A block's footprint is `launch_smem`.
- R8: A `done_valid` pulse naming slot `done_mp` returns one block's resources from that slot. The freed space can be offered from the next cycle on.
- R9: `grid_done` rises in the cycle after the edge at which the last completion is taken, or after a launch of zero blocks. It stays high until the next accepted launch, and no block is offered while it is high.
- R10: A launch with `launch_threads` > MAX_THR, a register footprint > MAX_REG, or `launch_smem` > MAX_SMEM sets `launch_err` from the next cycle until the next accepted launch and dispatches nothing.
- R11: A launch while a grid is running is ignored. The running grid continues with its own parameters and no error is raised.
- R12: While `disp_valid` is high and `disp_ready` is low, `disp_valid` stays high and `disp_block_id` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch command strobe |
| launch_blocks | input | GRID_W | Number of blocks in the grid |
| launch_threads | input | LT_W | Threads per block |
| launch_rpt | input | RPT_W | Registers per thread |
| launch_smem | input | LS_W | Shared-memory bytes per block |
| disp_valid | output | 1 | A block is offered |
| disp_ready | input | 1 | Receiver takes the offered block |
| disp_block_id | output | GRID_W | ID of the offered block |
| disp_mp | output | MP_W | Slot chosen for the offered block |
| done_valid | input | 1 | A block finished |
| done_mp | input | MP_W | Slot whose block finished |
| grid_done | output | 1 | All blocks dispatched and completed |
| launch_err | output | 1 | Last launch was refused as oversized |

## Verification
The bench drives each resource limit to saturation separately: small blocks to hit the block cap, 256-thread blocks to hit the thread cap, register-heavy blocks and shared-memory-heavy blocks. A design that checked only some of the limits would place too many blocks on slot 0 and show a wrong per-slot count. A single completion is aimed at a middle slot while every slot is full. A design that failed to release resources, or that picked the wrong slot, would then stall or offer some other slot. Oversized launches on each of the three axes must raise the error and leave the output quiet. A launch issued in the middle of a grid must not disturb block numbering. Random grids with random ready and completion traffic catch an early or missing grid-done and any slip in the lowest-slot choice.

// File: rtl/blkd_pkg.sv
package blkd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_e;

endpackage

// File: rtl/blkd_mp_slot.sv
// Resource ledger of one multiprocessor slot: resident blocks, threads,
// registers and shared memory, with a combined fit test for one more block.
module blkd_mp_slot #(
    parameter int MAX_BLK     = 8,
    parameter int MAX_THR     = 768,
    parameter int MAX_REG     = 8192,
    parameter int MAX_SMEM    = 16384,
    parameter int NEED_THR_W  = 11,
    parameter int NEED_REG_W  = 19,
    parameter int NEED_SMEM_W = 17
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   add,
    input  logic                   sub,
    input  logic [NEED_THR_W-1:0]  need_thr,
    input  logic [NEED_REG_W-1:0]  need_reg,
    input  logic [NEED_SMEM_W-1:0] need_smem,
    output logic                   fits,
    output logic                   occupied
);
    localparam int BLK_W  = $clog2(MAX_BLK + 1);
    localparam int THR_W  = $clog2(MAX_THR + 1);
    localparam int REG_W  = $clog2(MAX_REG + 1);
    localparam int SMEM_W = $clog2(MAX_SMEM + 1);

    localparam logic [31:0] LIM_BLK  = 32'(MAX_BLK);
    localparam logic [31:0] LIM_THR  = 32'(MAX_THR);
    localparam logic [31:0] LIM_REG  = 32'(MAX_REG);
    localparam logic [31:0] LIM_SMEM = 32'(MAX_SMEM);

    typedef struct packed {
        logic [BLK_W-1:0]  blk;
        logic [THR_W-1:0]  thr;
        logic [REG_W-1:0]  regs;
        logic [SMEM_W-1:0] smem;
    } ledger_t;

    ledger_t led_d, led_q;

    logic [31:0] thr_sum, reg_sum, smem_sum;
    logic        rel;

    assign thr_sum  = 32'(led_q.thr)  + 32'(need_thr);
    assign reg_sum  = 32'(led_q.regs) + 32'(need_reg);
    assign smem_sum = 32'(led_q.smem) + 32'(need_smem);

    assign occupied = (led_q.blk != '0);
    assign rel      = sub && occupied;
    assign fits     = (32'(led_q.blk) < LIM_BLK) && (thr_sum <= LIM_THR) &&
                      (reg_sum <= LIM_REG) && (smem_sum <= LIM_SMEM);

    always_comb begin
        led_d = led_q;
        if (add && !rel) begin
            led_d.blk  = led_q.blk  + BLK_W'(1);
            led_d.thr  = led_q.thr  + THR_W'(need_thr);
            led_d.regs = led_q.regs + REG_W'(need_reg);
            led_d.smem = led_q.smem + SMEM_W'(need_smem);
        end else if (rel && !add) begin
            led_d.blk  = led_q.blk  - BLK_W'(1);
            led_d.thr  = led_q.thr  - THR_W'(need_thr);
            led_d.regs = led_q.regs - REG_W'(need_reg);
            led_d.smem = led_q.smem - SMEM_W'(need_smem);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_q <= '0;
        end else begin
            led_q <= led_d;
        end
    end

endmodule

// File: rtl/blkd_pick.sv
// Lowest-index selector over the slot fit vector.
module blkd_pick #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/blk_dispatch.sv
module blk_dispatch
    import blkd_pkg::*;
#(
    parameter int NUM_MP   = 16,
    parameter int MAX_BLK  = 8,
    parameter int MAX_THR  = 768,
    parameter int MAX_REG  = 8192,
    parameter int MAX_SMEM = 16384,
    parameter int GRID_W   = 16,
    parameter int LT_W     = 11,
    parameter int RPT_W    = 8,
    parameter int LS_W     = 17,
    parameter int MP_W     = (NUM_MP > 1) ? $clog2(NUM_MP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_valid,
    input  logic [GRID_W-1:0] launch_blocks,
    input  logic [LT_W-1:0]   launch_threads,
    input  logic [RPT_W-1:0]  launch_rpt,
    input  logic [LS_W-1:0]   launch_smem,
    output logic              disp_valid,
    input  logic              disp_ready,
    output logic [GRID_W-1:0] disp_block_id,
    output logic [MP_W-1:0]   disp_mp,
    input  logic              done_valid,
    input  logic [MP_W-1:0]   done_mp,
    output logic              grid_done,
    output logic              launch_err
);
    localparam int PROD_W = LT_W + RPT_W;

    typedef struct packed {
        run_state_e        st;
        logic [GRID_W-1:0] total;
        logic [GRID_W-1:0] next_id;
        logic [GRID_W-1:0] finished;
        logic [LT_W-1:0]   thr;
        logic [PROD_W-1:0] regs;
        logic [LS_W-1:0]   smem;
        logic              err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_MP-1:0] fit_vec;
    logic [NUM_MP-1:0] occ_vec;
    logic              any_fit;
    logic [MP_W-1:0]   pick_idx;
    logic              fire;
    logic              done_hit;
    logic              rel;
    logic [PROD_W-1:0] launch_regs;
    logic              oversize;

    // Per-block register footprint of the incoming launch and its size test.
    assign launch_regs = PROD_W'(launch_threads) * PROD_W'(launch_rpt);
    assign oversize    = (32'(launch_threads) > 32'(MAX_THR)) ||
                         (32'(launch_regs)    > 32'(MAX_REG)) ||
                         (32'(launch_smem)    > 32'(MAX_SMEM));

    // Per-slot ledgers.
    for (genvar g = 0; g < NUM_MP; g++) begin : g_slot
        blkd_mp_slot #(
            .MAX_BLK    (MAX_BLK),
            .MAX_THR    (MAX_THR),
            .MAX_REG    (MAX_REG),
            .MAX_SMEM   (MAX_SMEM),
            .NEED_THR_W (LT_W),
            .NEED_REG_W (PROD_W),
            .NEED_SMEM_W(LS_W)
        ) slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .add      (fire && (pick_idx == MP_W'(g))),
            .sub      (rel && (done_mp == MP_W'(g))),
            .need_thr (ctl_q.thr),
            .need_reg (ctl_q.regs),
            .need_smem(ctl_q.smem),
            .fits     (fit_vec[g]),
            .occupied (occ_vec[g])
        );
    end

    blkd_pick #(
        .N    (NUM_MP),
        .IDX_W(MP_W)
    ) pick_i (
        .req(fit_vec),
        .any(any_fit),
        .idx(pick_idx)
    );

    assign disp_valid    = (ctl_q.st == ST_RUN) && (ctl_q.next_id != ctl_q.total) && any_fit;
    assign disp_block_id = ctl_q.next_id;
    assign disp_mp       = pick_idx;
    assign grid_done     = (ctl_q.st == ST_DONE);
    assign launch_err    = ctl_q.err;

    assign fire     = disp_valid && disp_ready;
    assign done_hit = (32'(done_mp) < 32'(NUM_MP)) ? occ_vec[done_mp] : 1'b0;
    assign rel      = done_valid && (ctl_q.st == ST_RUN) && done_hit;

    always_comb begin
        logic [GRID_W-1:0] nid;
        logic [GRID_W-1:0] nfin;
        ctl_d = ctl_q;
        nid   = ctl_q.next_id + GRID_W'(fire);
        nfin  = ctl_q.finished + GRID_W'(rel);
        if (ctl_q.st == ST_RUN) begin
            ctl_d.next_id  = nid;
            ctl_d.finished = nfin;
            if ((nid == ctl_q.total) && (nfin == ctl_q.total)) begin
                ctl_d.st = ST_DONE;
            end
        end
        if (launch_valid && (ctl_q.st != ST_RUN)) begin
            if (oversize) begin
                ctl_d.st  = ST_IDLE;
                ctl_d.err = 1'b1;
            end else begin
                ctl_d.total    = launch_blocks;
                ctl_d.next_id  = '0;
                ctl_d.finished = '0;
                ctl_d.thr      = launch_threads;
                ctl_d.regs     = launch_regs;
                ctl_d.smem     = launch_smem;
                ctl_d.err      = 1'b0;
                ctl_d.st       = (launch_blocks == '0) ? ST_DONE : ST_RUN;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/blkd_chk.sv
module blkd_chk #(
    parameter int NUM_MP  = 16,
    parameter int MAX_BLK = 8,
    parameter int GRID_W  = 16,
    parameter int MP_W    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              launch_valid,
    input logic              disp_valid,
    input logic              disp_ready,
    input logic [GRID_W-1:0] disp_block_id,
    input logic [MP_W-1:0]   disp_mp,
    input logic              done_valid,
    input logic [MP_W-1:0]   done_mp,
    input logic              grid_done,
    input logic              launch_err
);
    // Blocks resident per slot, reconstructed from the port traffic only.
    int unsigned res_cnt [NUM_MP];

    for (genvar g = 0; g < NUM_MP; g++) begin : g_cnt
        logic up, dn;
        assign up = disp_valid && disp_ready && (disp_mp == MP_W'(g));
        assign dn = done_valid && (done_mp == MP_W'(g)) && (res_cnt[g] != 0);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_cnt[g] <= 0;
            end else if (up && !dn) begin
                res_cnt[g] <= res_cnt[g] + 1;
            end else if (dn && !up) begin
                res_cnt[g] <= res_cnt[g] - 1;
            end
        end

        AST_BLK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            res_cnt[g] <= MAX_BLK); // R4
    end

    AST_MP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (32'(disp_mp) < 32'(NUM_MP))); // R3

    AST_ID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=>
            (!disp_valid || (disp_block_id == $past(disp_block_id) + GRID_W'(1)))); // R2

    AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_block_id))); // R12

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        grid_done |-> !disp_valid); // R9

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (grid_done && !launch_valid) |=> grid_done); // R9

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        launch_err |-> !disp_valid); // R10

endmodule

bind blk_dispatch blkd_chk #(
    .NUM_MP (NUM_MP),
    .MAX_BLK(MAX_BLK),
    .GRID_W (GRID_W),
    .MP_W   (MP_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch_valid (launch_valid),
    .disp_valid   (disp_valid),
    .disp_ready   (disp_ready),
    .disp_block_id(disp_block_id),
    .disp_mp      (disp_mp),
    .done_valid   (done_valid),
    .done_mp      (done_mp),
    .grid_done    (grid_done),
    .launch_err   (launch_err)
);

// File: tb/blk_dispatch_tb.sv
module blk_dispatch_tb_top;
    localparam int NMP   = 16;
    localparam int LBLK  = 8;
    localparam int LTHR  = 768;
    localparam int LREG  = 8192;
    localparam int LSMEM = 16384;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        launch_valid = 1'b0;
    logic [15:0] launch_blocks = '0;
    logic [10:0] launch_threads = '0;
    logic [7:0]  launch_rpt = '0;
    logic [16:0] launch_smem = '0;
    logic        disp_valid;
    logic        disp_ready = 1'b0;
    logic [15:0] disp_block_id;
    logic [3:0]  disp_mp;
    logic        done_valid = 1'b0;
    logic [3:0]  done_mp = '0;
    logic        grid_done;
    logic        launch_err;

    always #10 clk = ~clk;

    blk_dispatch dut_i (
        .clk(clk), .rst_n(rst_n),
        .launch_valid(launch_valid), .launch_blocks(launch_blocks),
        .launch_threads(launch_threads), .launch_rpt(launch_rpt), .launch_smem(launch_smem),
        .disp_valid(disp_valid), .disp_ready(disp_ready),
        .disp_block_id(disp_block_id), .disp_mp(disp_mp),
        .done_valid(done_valid), .done_mp(done_mp),
        .grid_done(grid_done), .launch_err(launch_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit wd = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) wd <= 1'b1;
    end

    // Bench model of the slots and the grid, built from the requirements.
    int m_blk [NMP];
    int m_thr [NMP];
    int m_reg [NMP];
    int m_sm  [NMP];
    int obs   [NMP];
    int g_total, g_next, g_fin, g_T, g_R, g_S;
    bit g_run, g_done, g_err;
    bit stalled;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_pick();
        for (int m = 0; m < NMP; m++) begin
            if (m_blk[m] < LBLK && m_thr[m] + g_T <= LTHR &&
                m_reg[m] + g_R <= LREG && m_sm[m] + g_S <= LSMEM) return m;
        end
        return -1;
    endfunction

    // One cycle: check outputs, drive inputs, advance the model.
    task automatic step(input int rdy_pct, input int cmp_pct, input int force_mp, input bit poke);
        int  p;
        bit  ev;
        bit  rdy;
        int  dm;
        p  = exp_pick();
        ev = g_run && (g_next < g_total) && (p >= 0);
        chk(disp_valid == ev, "R2 disp_valid", int'(disp_valid), int'(ev));
        if (ev && disp_valid) begin
            chk(int'(disp_mp) == p, "R3 disp_mp", int'(disp_mp), p);
            chk(int'(disp_block_id) == g_next, stalled ? "R12 held id" : "R2 block id",
                int'(disp_block_id), g_next);
        end
        chk(grid_done == g_done, "R9 grid_done", int'(grid_done), int'(g_done));
        chk(launch_err == g_err, "R10 launch_err", int'(launch_err), int'(g_err));

        rdy = (($urandom % 100) < rdy_pct);
        dm = -1;
        if (force_mp >= 0) begin
            dm = force_mp;
        end else if (($urandom % 100) < cmp_pct) begin
            int off;
            off = $urandom % NMP;
            for (int k = 0; k < NMP; k++) begin
                if (m_blk[(off + k) % NMP] > 0) begin
                    dm = (off + k) % NMP;
                    break;
                end
            end
        end
        disp_ready     = rdy;
        done_valid     = (dm >= 0);
        done_mp        = (dm >= 0) ? 4'(dm) : 4'd0;
        launch_valid   = poke;
        launch_blocks  = 16'd5;
        launch_threads = 11'd1;
        launch_rpt     = 8'd1;
        launch_smem    = 17'd0;

        stalled = ev && !rdy;
        if (ev && rdy) begin
            m_blk[p]++; m_thr[p] += g_T; m_reg[p] += g_R; m_sm[p] += g_S;
            obs[p]++;
            g_next++;
        end
        if (dm >= 0 && g_run && m_blk[dm] > 0) begin
            m_blk[dm]--; m_thr[dm] -= g_T; m_reg[dm] -= g_R; m_sm[dm] -= g_S;
            g_fin++;
        end
        if (g_run && g_next == g_total && g_fin == g_total) begin
            g_run  = 0;
            g_done = 1;
        end
        @(negedge clk);
    endtask

    task automatic launch(input int n, input int t, input int rpt, input int s);
        launch_valid   = 1'b1;
        launch_blocks  = 16'(n);
        launch_threads = 11'(t);
        launch_rpt     = 8'(rpt);
        launch_smem    = 17'(s);
        disp_ready     = 1'b0;
        done_valid     = 1'b0;
        if (!g_run) begin
            if (t > LTHR || t * rpt > LREG || s > LSMEM) begin
                g_err = 1; g_done = 0;
            end else begin
                g_total = n; g_next = 0; g_fin = 0;
                g_T = t; g_R = t * rpt; g_S = s;
                g_err = 0; g_done = (n == 0); g_run = (n != 0);
                for (int m = 0; m < NMP; m++) obs[m] = 0;
            end
        end
        stalled = 0;
        @(negedge clk);
        launch_valid = 1'b0;
    endtask

    task automatic drain(input int rdy_pct, input int cmp_pct);
        while (g_run && !wd) step(rdy_pct, cmp_pct, -1, 1'b0);
        step(rdy_pct, 0, -1, 1'b0);
    endtask

    task automatic saturate(input int n, input int t, input int rpt, input int s,
                            input int per_mp, input string tag);
        launch(n, t, rpt, s);
        for (int c = 0; c < 140; c++) step(100, 0, -1, 1'b0);
        for (int m = 0; m < NMP; m++) begin
            chk(obs[m] == per_mp, tag, obs[m], per_mp);
        end
        chk(disp_valid == 1'b0, tag, int'(disp_valid), 0);
        drain(100, 40);
        chk(grid_done == 1'b1, "R9 done after drain", int'(grid_done), 1);
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int m = 0; m < NMP; m++) begin
            m_blk[m] = 0; m_thr[m] = 0; m_reg[m] = 0; m_sm[m] = 0; obs[m] = 0;
        end
        g_total = 0; g_next = 0; g_fin = 0; g_T = 0; g_R = 0; g_S = 0;
        g_run = 0; g_done = 0; g_err = 0; stalled = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        chk(disp_valid == 1'b0, "R1 disp_valid", int'(disp_valid), 0);
        chk(grid_done == 1'b0, "R1 grid_done", int'(grid_done), 0);
        chk(launch_err == 1'b0, "R1 launch_err", int'(launch_err), 0);

        // R9: empty grid finishes at once and stays finished
        launch(0, 32, 1, 0);
        chk(grid_done == 1'b1, "R9 empty grid", int'(grid_done), 1);
        step(100, 0, -1, 1'b0);
        step(100, 0, -1, 1'b0);

        // Per-limit saturation
        saturate(300, 32, 1, 0, 8, "R4 block cap per slot");
        saturate(100, 256, 1, 0, 3, "R5 thread cap per slot");
        saturate(100, 64, 32, 0, 4, "R6 register cap per slot");
        saturate(100, 32, 1, 6000, 2, "R7 shared memory cap per slot");

        // R8: backfill after one completion on a full slot 7
        launch(60, 256, 1, 0);
        for (int c = 0; c < 60; c++) step(100, 0, -1, 1'b0);
        chk(disp_valid == 1'b0, "R8 all slots full", int'(disp_valid), 0);
        step(0, 0, 7, 1'b0);
        chk(disp_valid == 1'b1, "R8 backfill offered", int'(disp_valid), 1);
        chk(int'(disp_mp) == 7, "R8 backfill slot", int'(disp_mp), 7);
        drain(80, 40);

        // R10: oversize launches on each axis
        launch(10, 769, 1, 0);
        for (int c = 0; c < 3; c++) step(100, 0, -1, 1'b0);
        chk(launch_err == 1'b1, "R10 thread oversize", int'(launch_err), 1);
        launch(10, 512, 20, 0);
        for (int c = 0; c < 3; c++) step(100, 0, -1, 1'b0);
        chk(launch_err == 1'b1, "R10 register oversize", int'(launch_err), 1);
        launch(10, 32, 1, 16385);
        for (int c = 0; c < 3; c++) step(100, 0, -1, 1'b0);
        chk(disp_valid == 1'b0, "R10 no dispatch", int'(disp_valid), 0);
        launch(5, 32, 1, 0);
        chk(launch_err == 1'b0, "R10 error cleared", int'(launch_err), 0);
        drain(100, 50);

        // R11: launch pokes during a running grid are ignored
        launch(80, 128, 4, 1024);
        for (int c = 0; c < 200 && g_run; c++) step(70, 30, -1, (c % 3) == 0);
        chk(launch_err == 1'b0, "R11 no error from ignored launch", int'(launch_err), 0);
        drain(70, 40);

        // Random grids
        for (int gi = 0; gi < 25 && !wd; gi++) begin
            int n, t, r, s;
            n = 1 + ($urandom % 200);
            t = 1 + ($urandom % 800);
            r = 1 + ($urandom % 24);
            s = $urandom % 17000;
            launch(n, t, r, s);
            if (g_run) drain(10 + ($urandom % 90), 10 + ($urandom % 60));
            else step(100, 0, -1, 1'b0);
        end

        chk(!wd, "watchdog", int'(wd), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule